// File: doc/BRIEF.md
# CRC-16 Receive Frame Checker

This block sits on the receive side of a byte-wide link and checks each frame against the 16-bit CRC word that came with it. Frame bytes arrive one per clock, each qualified by a valid strobe. A start pulse opens each frame, and the final byte carries an end marker. The block folds every accepted byte into a running 16-bit remainder, eight bits per clock. One clock after the final byte it compares the finished remainder with the received CRC word. It then reports a verdict that stays in place until the next frame opens.

The remainder uses the reflected form of the generator x^16 + x^15 + x^2 + 1. Bits are consumed least significant first, and the remainder starts at all ones. The finished value is inverted before the comparison, the same way a sender inverts it before appending it. A parameter selects how the per-byte update is built. One option is an unrolled XOR network. The other is a 256-entry table indexed by the low remainder byte XOR the data byte, then combined with the shifted remainder. Both options produce the same remainder.

Top module: `crc16_rx_check`

## Requirements
- R1: For a frame whose received word equals the bitwise inverse of the remainder, `chk_done_o` goes to 1 and `crc_err_o` to 0. The remainder is built from seed 0xFFFF, with reflected polynomial 0xA001 applied per bit, LSB first. The ASCII bytes "123456789" pair with the word 0xB4C8.
- R2: If any data bit is altered and the received word is unchanged, `crc_err_o` reads 1 once the check completes.
- R3: If the data is intact and the received word is altered, `crc_err_o` reads 1.
- R4: If both the data and the received word are altered so that they no longer correspond, `crc_err_o` reads 1.
- R5: `chk_done_o` is still 0 after the clock edge that accepts the end-marked byte, and becomes 1 after the following edge.
- R6: Once `chk_done_o` is 1, `chk_done_o` and `crc_err_o` hold their values and further bytes are ignored until the next `frame_start_i`. `crc_err_o` is never 1 while `chk_done_o` is 0.
- R7: `frame_start_i` clears `chk_done_o` and `crc_err_o` on the next edge and reloads the remainder with the seed. A byte that is valid in the same cycle as `frame_start_i` is taken as the frame's first byte.
- R8: Cycles with `byte_vld_i` low leave the remainder unchanged, so idle gaps between bytes do not alter the verdict.
- R9: `rx_crc_i` is sampled only in the cycle of the end-marked byte. Its value at any other time has no effect.
- R10: The XOR-network variant (`USE_LUT`=0) and the table variant (`USE_LUT`=1) give identical outputs for the same input sequence.
- R11: After reset, `chk_done_o` and `crc_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Opens a new frame: clears the verdict and reseeds the remainder |
| byte_vld_i | input | 1 | The data byte is valid this cycle |
| byte_data_i | input | 8 | Frame data byte |
| byte_last_i | input | 1 | Marks the final byte of the frame |
| rx_crc_i | input | 16 | Received CRC word, taken with the final byte |
| chk_done_o | output | 1 | The check for the current frame is complete |
| crc_err_o | output | 1 | The recomputed CRC does not match the received word |

## Verification
The checker is exercised with several frames:
- A known nine-byte string with its published check word, which pins down polynomial, seed, bit order and final inversion together.
- A one-byte frame.
- A frame with idle gaps between bytes, which separates correct gating of the valid strobe from simple per-clock updating.

Three corrupted cases are run: data only, CRC word only, and both. Each must raise the error flag, which shows that the comparison catches damage on either side.

Two further cases show that only the sampling points count. In one, garbage is driven on the CRC input outside the end-marked cycle. In the other, extra bytes are sent after the verdict. Throughout, a table-based copy runs beside the XOR-based one, and every verdict of the two is compared.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int DATA_W = 8;
  localparam int CRC_W  = 16;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CRC_W-1:0]  crc_t;

  // One byte folded into a reflected remainder, one bit at a time, LSB first.
  function automatic crc_t fold_byte(input crc_t rem, input data_t d, input crc_t poly);
    crc_t c;
    logic fb;
    c = rem;
    for (int b = 0; b < DATA_W; b++) begin
      fb = c[0] ^ d[b];
      c  = c >> 1;
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/crc16_xor_step.sv
module crc16_xor_step
  import crc16_pkg::*;
#(
  parameter crc_t POLY = 16'hA001
) (
  input  crc_t  crc_i,
  input  data_t data_i,
  output crc_t  crc_o
);
  // Unrolled bit loop collapses into a flat XOR network per output bit.
  always_comb begin
    crc_o = fold_byte(crc_i, data_i, POLY);
  end
endmodule

// File: rtl/crc16_lut_step.sv
module crc16_lut_step
  import crc16_pkg::*;
#(
  parameter crc_t POLY = 16'hA001
) (
  input  crc_t  crc_i,
  input  data_t data_i,
  output crc_t  crc_o
);
  localparam int TBL_N = 1 << DATA_W;

  crc_t  tbl [TBL_N];
  data_t idx;

  // Each entry: remainder contribution of one index byte with no data.
  for (genvar k = 0; k < TBL_N; k++) begin : g_tbl
    assign tbl[k] = fold_byte(crc_t'(k), data_t'(0), POLY);
  end

  assign idx   = crc_i[DATA_W-1:0] ^ data_i;
  assign crc_o = (crc_i >> DATA_W) ^ tbl[idx];
endmodule

// File: rtl/crc16_rx_check.sv
module crc16_rx_check
  import crc16_pkg::*;
#(
  parameter bit   USE_LUT = 1'b0,
  parameter crc_t POLY    = 16'hA001,
  parameter crc_t SEED    = 16'hFFFF,
  parameter crc_t XOR_OUT = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              byte_last_i,
  input  logic [CRC_W-1:0]  rx_crc_i,
  output logic              chk_done_o,
  output logic              crc_err_o
);
  crc_t crc_q, crc_d, base_crc, step_crc;
  crc_t rxc_q, rxc_d;
  logic pend_q, pend_d;
  logic done_q, done_d;
  logic err_q, err_d;
  logic accept_w, acc_last_w;
  logic crc_en, rxc_en, vrd_en;

  // A byte is taken while the frame is open, or together with a new start.
  assign accept_w   = byte_vld_i && (frame_start_i || (!done_q && !pend_q));
  assign acc_last_w = accept_w && byte_last_i;
  assign base_crc   = frame_start_i ? SEED : crc_q;

  if (USE_LUT) begin : g_lut
    crc16_lut_step #(.POLY(POLY)) u_step (
      .crc_i (base_crc),
      .data_i(byte_data_i),
      .crc_o (step_crc)
    );
  end else begin : g_xor
    crc16_xor_step #(.POLY(POLY)) u_step (
      .crc_i (base_crc),
      .data_i(byte_data_i),
      .crc_o (step_crc)
    );
  end

  // Next-state logic
  always_comb begin
    crc_en = frame_start_i || accept_w;
    crc_d  = accept_w ? step_crc : SEED;

    rxc_en = acc_last_w;
    rxc_d  = rx_crc_i;

    pend_d = acc_last_w;

    vrd_en = frame_start_i || pend_q;
    if (frame_start_i) begin
      done_d = 1'b0;
      err_d  = 1'b0;
    end else begin
      done_d = 1'b1;
      err_d  = (crc_q ^ XOR_OUT) != rxc_q;
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= SEED;
      rxc_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (crc_en) crc_q <= crc_d;
      if (rxc_en) rxc_q <= rxc_d;
      pend_q <= pend_d;
      if (vrd_en) begin
        done_q <= done_d;
        err_q  <= err_d;
      end
    end
  end

  assign chk_done_o = done_q;
  assign crc_err_o  = err_q;
endmodule

// File: rtl/crc16_rx_check_sva.sv
module crc16_rx_check_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic frame_start_i,
  input logic acc_last,
  input logic chk_done_o,
  input logic crc_err_o
);
  p_done_two_edges_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_last && !frame_start_i) ##1 !frame_start_i |=> chk_done_o);

  p_done_not_early_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_last |=> !chk_done_o);

  p_done_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_done_o && !frame_start_i |=> chk_done_o);

  p_err_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_done_o && !frame_start_i |=> $stable(crc_err_o));

  p_err_only_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |-> chk_done_o);

  p_start_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !chk_done_o && !crc_err_o);

  always_comb begin
    if (!rst_ni) begin
      a_reset_quiet_r11: assert (!chk_done_o && !crc_err_o);
    end
  end
endmodule

bind crc16_rx_check crc16_rx_check_sva u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .acc_last     (acc_last_w),
  .chk_done_o   (chk_done_o),
  .crc_err_o    (crc_err_o)
);

// File: tb/crc16_rx_check_tb.sv
`timescale 1ns/1ps
module crc16_rx_check_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fs, vld, last;
  logic [7:0]  dat;
  logic [15:0] rxc;
  logic        done_x, err_x, done_l, err_l;
  int          total = 0;
  int          bad = 0;

  always #2 clk = ~clk;

  crc16_rx_check #(.USE_LUT(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .byte_vld_i(vld),
    .byte_data_i(dat), .byte_last_i(last), .rx_crc_i(rxc),
    .chk_done_o(done_x), .crc_err_o(err_x));

  crc16_rx_check #(.USE_LUT(1'b1)) dut_lut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .byte_vld_i(vld),
    .byte_data_i(dat), .byte_last_i(last), .rx_crc_i(rxc),
    .chk_done_o(done_l), .crc_err_o(err_l));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Inverted reflected CRC, seed all ones, LSB first (R1).
  function automatic logic [15:0] ref_crc(input logic [7:0] m [16], input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ m[i][b]) ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    return ~c;
  endfunction

  task automatic put(input logic s, input logic v, input logic l,
                     input logic [7:0] d, input logic [15:0] c);
    @(negedge clk);
    fs = s; vld = v; last = l; dat = d; rxc = c;
    @(posedge clk);
    #1;
    fs = 0; vld = 0; last = 0; dat = 8'h00; rxc = 16'hDEAD;
  endtask

  task automatic cmp_variants(input string tag);
    chk({"R10 done ", tag}, 16'(done_l), 16'(done_x));
    chk({"R10 err ", tag}, 16'(err_l), 16'(err_x));
  endtask

  // Send a frame; check verdict timing and value.
  task automatic run_frame(input logic [7:0] m [16], input int n, input logic [15:0] word,
                           input bit gaps, input bit late_junk, input logic exp_err,
                           input string tag);
    for (int i = 0; i < n; i++) begin
      put(i == 0, 1'b1, i == n - 1, m[i], (i == n - 1) ? word : 16'h1234 ^ 16'(i));
      if (gaps && i != n - 1) begin
        put(1'b0, 1'b0, 1'b1, 8'h5A, 16'hBEEF);
        put(1'b0, 1'b0, 1'b0, 8'hC3, 16'h0F0F);
      end
    end
    if (late_junk) begin
      @(negedge clk);
      rxc = ~word;
    end else begin
      @(negedge clk);
    end
    chk({"R5 not yet done ", tag}, 16'(done_x), 16'd0);
    @(negedge clk);
    chk({"R5 done ", tag}, 16'(done_x), 16'd1);
    chk({tag, " err"}, 16'(err_x), 16'(exp_err));
    cmp_variants(tag);
  endtask

  task automatic t_reset();
    chk("R11 done after reset", 16'(done_x), 16'd0);
    chk("R11 err after reset", 16'(err_x), 16'd0);
  endtask

  task automatic t_known(ref logic [7:0] m [16]);
    chk("R1 model check word", ref_crc(m, 9), 16'hB4C8);
    run_frame(m, 9, 16'hB4C8, 0, 0, 1'b0, "R1 known string");
  endtask

  task automatic t_single();
    logic [7:0] s [16];
    foreach (s[i]) s[i] = 8'h00;
    s[0] = 8'hA5;
    run_frame(s, 1, ref_crc(s, 1), 0, 0, 1'b0, "R1 single byte");
  endtask

  task automatic t_data_bad(ref logic [7:0] m [16]);
    logic [7:0] x [16];
    x = m;
    x[3] ^= 8'h10;
    run_frame(x, 9, 16'hB4C8, 0, 0, 1'b1, "R2 data corrupted");
  endtask

  task automatic t_crc_bad(ref logic [7:0] m [16]);
    run_frame(m, 9, 16'hB4C8 ^ 16'h0100, 0, 0, 1'b1, "R3 word corrupted");
  endtask

  task automatic t_both_bad(ref logic [7:0] m [16]);
    logic [7:0] x [16];
    logic [15:0] w;
    x = m;
    x[7] ^= 8'h81;
    w = 16'hB4C8 ^ 16'h0001;
    run_frame(x, 9, w, 0, 0, ref_crc(x, 9) != w, "R4 both corrupted");
  endtask

  task automatic t_hold(ref logic [7:0] m [16]);
    run_frame(m, 9, 16'hB4C8, 0, 0, 1'b0, "R6 setup good");
    put(1'b0, 1'b1, 1'b0, 8'h77, 16'h0000);
    put(1'b0, 1'b1, 1'b1, 8'h99, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R6 done held", 16'(done_x), 16'd1);
    chk("R6 err held low after extra bytes", 16'(err_x), 16'd0);
    run_frame(m, 9, 16'h0000, 0, 0, 1'b1, "R6 setup bad");
    put(1'b0, 1'b1, 1'b1, 8'h31, ref_crc(m, 9));
    repeat (2) @(negedge clk);
    chk("R6 err held high after extra bytes", 16'(err_x), 16'd1);
    cmp_variants("R6 hold");
  endtask

  task automatic t_clear(ref logic [7:0] m [16]);
    put(1'b1, 1'b0, 1'b0, 8'h00, 16'h0000);
    @(negedge clk);
    chk("R7 start clears done", 16'(done_x), 16'd0);
    chk("R7 start clears err", 16'(err_x), 16'd0);
    run_frame(m, 9, 16'hB4C8, 0, 0, 1'b0, "R7 reseed after bad frame");
  endtask

  task automatic t_gaps(ref logic [7:0] m [16]);
    run_frame(m, 9, 16'hB4C8, 1, 0, 1'b0, "R8 idle gaps");
  endtask

  task automatic t_late(ref logic [7:0] m [16]);
    run_frame(m, 9, 16'hB4C8, 0, 1, 1'b0, "R9 word changed after last byte");
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] msg [16];
    string s = "123456789";
    foreach (msg[i]) msg[i] = 8'h00;
    for (int i = 0; i < 9; i++) msg[i] = s[i];
    fs = 0; vld = 0; last = 0; dat = 8'h00; rxc = 16'h0000;
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_known(msg);
    t_single();
    t_data_bad(msg);
    t_crc_bad(msg);
    t_both_bad(msg);
    t_hold(msg);
    t_clear(msg);
    t_gaps(msg);
    t_late(msg);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule